// File: doc/BRIEF.md
# Eight-Point Inverse DCT with Pixel Reconstruction

This block takes one vector of eight signed 16-bit transform coefficients and returns the one-dimensional 8-point inverse discrete cosine transform of that vector. The transform is an exact integer butterfly network. Every constant multiply uses 14-bit fixed-point cosine weights and is followed by a rounding shift, so the results match an integer reference model bit for bit. A decoder uses it once per row and once per column of an 8x8 block. The transposition and sequencing between those passes are handled outside.

Each vector carries a mode bit. In transform mode the block returns the eight 16-bit results. In reconstruct mode, which is meant for the final column pass, it also scales each result down by 32 with rounding, adds it to the matching 8-bit prediction pixel and clamps the sum to a pixel value. Vectors move through a two-stage pipeline with a valid/ready handshake on both sides. The first stage holds the even-half results and the first odd rotation. The second stage holds the finished outputs.

Top module: `idct8_recon`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0, `in_ready` is 1, and `out_res` and `out_pix` are all zeros until the first result arrives.
- R2: Every constant multiply is rounded by adding 8192 to the product sum and shifting arithmetically right by 14. As an example, a vector with coefficient 0 equal to 1 and all others 0 yields 1 in all eight results, and the same vector with -1 yields -1 in all eight.
- R3: With lane k of `in_coef` at bits [16k+15:16k], the weights are w4=16069, w8=15137, w12=13623, w16=11585, w20=9102, w24=6270 and w28=3196, and rnd(v) is the R2 rounding. The even half is:
  - p0=rnd((x0+x4)w16), p1=rnd((x0-x4)w16), p2=rnd(x2·w24-x6·w8), p3=rnd(x2·w8+x6·w24)
  - a0=p0+p3, a1=p1+p2, a2=p1-p2, a3=p0-p3

  The first odd rotation is:
  - q4=rnd(x1·w28-x7·w4), q7=rnd(x1·w4+x7·w28), q5=rnd(x5·w12-x3·w20), q6=rnd(x5·w20+x3·w12)

  The odd merge, using the values held before the merge, is:
  - m5=rnd((q7-q6-q4+q5)w16), m6=rnd((q4-q5-q6+q7)w16), m4=q4+q5, m7=q6+q7

  The outputs are y0=a0+m7, y1=a1+m6, y2=a2+m5, y3=a3+m4, y4=a3-m4, y5=a2-m5, y6=a1-m6 and y7=a0-m7. Each y is truncated to 16-bit two's complement in lane k of `out_res`, at bits [16k+15:16k].
- R4: In reconstruct mode (`in_recon`=1), lane k of `out_pix` at bits [8k+7:8k] equals clamp(pred_k + ((y_k + 16) >>> 5)). Here y_k is the untruncated sum and pred_k is lane k of `in_pred` at bits [8k+7:8k]. `out_res` still carries the 16-bit results.
- R5: The reconstructed pixel saturates at 0 for sums below 0 and at 255 for sums above 255.
- R6: A vector accepted at rising edge E, with `in_valid` and `in_ready` both high, is presented with `out_valid` high after edge E+1, as long as `out_ready` was high or the output stage was empty at that edge.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_res`, `out_pix` and `out_recon` hold their values.
- R8: `in_ready` goes low only when both stages hold a vector and `out_ready` is low. Every accepted vector leaves exactly once, in order.
- R9: With `out_ready` held high, `in_ready` stays high, so one vector is accepted on every cycle.
- R10: `out_recon` carries the mode bit of the vector being presented. In transform mode `out_pix` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector is present |
| in_ready | output | 1 | Block can take an input vector this cycle |
| in_coef | input | 128 | Eight signed 16-bit coefficients, lane k at [16k+15:16k] |
| in_pred | input | 64 | Eight unsigned 8-bit prediction pixels, lane k at [8k+7:8k] |
| in_recon | input | 1 | 1 = reconstruct mode, 0 = transform mode |
| out_valid | output | 1 | Output vector is present |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_res | output | 128 | Eight 16-bit transform results, lane k at [16k+15:16k] |
| out_pix | output | 64 | Eight reconstructed pixels; all zeros in transform mode |
| out_recon | output | 1 | Mode bit of the presented vector |

## Verification
A result is due one full cycle after the edge that accepts its vector. At the falling edge straight after acceptance, `out_valid` must still be low. At the next falling edge it must be high with the vector's data. The latency scenario checks exactly those two sample points, and the edge after that, where the output must empty again. All other scenarios sample inputs and outputs only at falling edges. They record an expected entry at the falling edge where `in_ready` is seen high with `in_valid`, and compare it against the output at the falling edge where `out_valid` and `out_ready` are both high. Because of this, the results do not depend on how long backpressure stretches the pipeline.

// File: rtl/idct8_pkg.sv
// Package: shared widths, cosine weights and the Q14 rounding helper for
// the eight-point inverse transform. Assumes 32-bit signed arithmetic is wide
// enough for every product sum of 16-bit coefficients with the Q14 weights.
package idct8_pkg;

    localparam int N_PT     = 8;                    // transform length
    localparam int N_HALF   = N_PT / 2;             // butterfly half size
    localparam int ACC_W    = 32;                   // internal arithmetic width
    localparam int FRAC_SH  = 14;                   // weight fraction bits

    typedef logic signed [ACC_W-1:0] acc_t;

    localparam acc_t RND_HALF = acc_t'(1) <<< (FRAC_SH - 1);

    // round(16384 * cos(k*pi/64)) for the angles the butterfly uses
    localparam acc_t W4  = 16069;
    localparam acc_t W8  = 15137;
    localparam acc_t W12 = 13623;
    localparam acc_t W16 = 11585;
    localparam acc_t W20 = 9102;
    localparam acc_t W24 = 6270;
    localparam acc_t W28 = 3196;

    // Add half an LSB of the Q14 fraction, then drop the fraction.
    function automatic acc_t rnd_q14(input acc_t v);
        return (v + RND_HALF) >>> FRAC_SH;
    endfunction

endpackage

// File: rtl/idct8_even.sv
// Even half of the butterfly: rotates coefficients 0, 2, 4, 6 and combines
// them into the four even partial outputs. Purely combinational; inputs are
// sign-extended coefficients.
module idct8_even
    import idct8_pkg::*;
(
    input  acc_t                  x0,
    input  acc_t                  x2,
    input  acc_t                  x4,
    input  acc_t                  x6,
    output acc_t [N_HALF-1:0]     even_o
);

    acc_t p0, p1, p2, p3;

    // Rotation of the even coefficients, each product sum rounded once.
    always_comb begin
        p0 = rnd_q14((x0 + x4) * W16);
        p1 = rnd_q14((x0 - x4) * W16);
        p2 = rnd_q14(x2 * W24 - x6 * W8);
        p3 = rnd_q14(x2 * W8 + x6 * W24);
    end

    // Sum/difference stage of the even half.
    always_comb begin
        even_o[0] = p0 + p3;
        even_o[1] = p1 + p2;
        even_o[2] = p1 - p2;
        even_o[3] = p0 - p3;
    end

endmodule

// File: rtl/idct8_odd_rot.sv
// First rotation of the odd half: coefficients 1, 3, 5, 7 become four rounded
// rotation terms, ordered q4, q5, q6, q7 in the output indices 0..3.
// Purely combinational.
module idct8_odd_rot
    import idct8_pkg::*;
(
    input  acc_t                  x1,
    input  acc_t                  x3,
    input  acc_t                  x5,
    input  acc_t                  x7,
    output acc_t [N_HALF-1:0]     rot_o
);

    // Two plane rotations, (1,7) and (5,3), each term rounded once.
    always_comb begin
        rot_o[0] = rnd_q14(x1 * W28 - x7 * W4);
        rot_o[3] = rnd_q14(x1 * W4 + x7 * W28);
        rot_o[1] = rnd_q14(x5 * W12 - x3 * W20);
        rot_o[2] = rnd_q14(x5 * W20 + x3 * W12);
    end

endmodule

// File: rtl/idct8_merge.sv
// Second half of the transform: merges the odd rotation terms (both rounded
// terms taken from the pre-merge values) and applies the final butterfly
// against the even partials. Outputs are full width, untruncated.
module idct8_merge
    import idct8_pkg::*;
(
    input  acc_t [N_HALF-1:0]     even_i,
    input  acc_t [N_HALF-1:0]     rot_i,
    output acc_t [N_PT-1:0]       y_o
);

    acc_t q4, q5, q6, q7;
    acc_t m4, m5, m6, m7;

    // Unpack the rotation terms so signedness is explicit.
    always_comb begin
        q4 = $signed(rot_i[0]);
        q5 = $signed(rot_i[1]);
        q6 = $signed(rot_i[2]);
        q7 = $signed(rot_i[3]);
    end

    // Odd merge: the rounded pair uses only the incoming values.
    always_comb begin
        m5 = rnd_q14((q7 - q6 - q4 + q5) * W16);
        m6 = rnd_q14((q4 - q5 - q6 + q7) * W16);
        m4 = q4 + q5;
        m7 = q6 + q7;
    end

    // Final butterfly: lane k pairs with lane N_PT-1-k.
    always_comb begin
        y_o[0] = $signed(even_i[0]) + m7;
        y_o[1] = $signed(even_i[1]) + m6;
        y_o[2] = $signed(even_i[2]) + m5;
        y_o[3] = $signed(even_i[3]) + m4;
        y_o[4] = $signed(even_i[3]) - m4;
        y_o[5] = $signed(even_i[2]) - m5;
        y_o[6] = $signed(even_i[1]) - m6;
        y_o[7] = $signed(even_i[0]) - m7;
    end

endmodule

// File: rtl/idct8_recon_lane.sv
// One reconstruct lane: scales a full-width transform result down by
// 2**SCALE_SH with rounding, adds an unsigned prediction pixel and clamps the
// sum to the pixel range. Combinational; the result is forced to zero when
// the lane is not in reconstruct mode.
module idct8_recon_lane
    import idct8_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int SCALE_SH = 5
) (
    input  acc_t                  y_i,
    input  logic [PIX_W-1:0]      pred_i,
    input  logic                  recon_i,
    output logic [PIX_W-1:0]      pix_o
);

    localparam acc_t SCALE_HALF = acc_t'(1) <<< (SCALE_SH - 1);
    localparam acc_t PIX_MAX    = (acc_t'(1) <<< PIX_W) - acc_t'(1);

    acc_t scaled;
    acc_t total;

    // Rounded down-scale followed by the prediction add.
    always_comb begin
        scaled = (y_i + SCALE_HALF) >>> SCALE_SH;
        total  = scaled + $signed({{(ACC_W-PIX_W){1'b0}}, pred_i});
    end

    // Clamp into [0, PIX_MAX], or zero in transform mode.
    always_comb begin
        if (!recon_i)
            pix_o = '0;
        else if (total < 0)
            pix_o = '0;
        else if (total > PIX_MAX)
            pix_o = '1;
        else
            pix_o = total[PIX_W-1:0];
    end

endmodule

// File: rtl/idct8_recon.sv
// Top: two-stage pipelined eight-point inverse DCT with optional
// reconstruction. Stage 1 registers the even partials and the first odd
// rotation; stage 2 registers the 16-bit results and reconstructed pixels.
// Assumes coefficients are two's complement COEF_W bits and pixels unsigned.
module idct8_recon
    import idct8_pkg::*;
#(
    parameter int COEF_W   = 16,
    parameter int PIX_W    = 8,
    parameter int SCALE_SH = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [N_PT*COEF_W-1:0]    in_coef,
    input  logic [N_PT*PIX_W-1:0]     in_pred,
    input  logic                      in_recon,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [N_PT*COEF_W-1:0]    out_res,
    output logic [N_PT*PIX_W-1:0]     out_pix,
    output logic                      out_recon
);

    localparam int RES_W = N_PT * COEF_W;
    localparam int PRD_W = N_PT * PIX_W;

    acc_t [N_PT-1:0]    coef_x;
    acc_t [N_HALF-1:0]  even_c, rot_c;
    acc_t [N_HALF-1:0]  s1_even, s1_rot;
    logic [PRD_W-1:0]   s1_pred;
    logic               s1_recon;
    logic               s1_valid;
    acc_t [N_PT-1:0]    y_c;
    logic [RES_W-1:0]   res_c;
    logic [PRD_W-1:0]   pix_c;
    logic               s1_en, s2_en;

    // Sign-extend each coefficient lane to the internal width.
    for (genvar k = 0; k < N_PT; k++) begin : g_ext
        assign coef_x[k] = acc_t'($signed(in_coef[k*COEF_W +: COEF_W]));
    end

    idct8_even u_even (
        .x0     (coef_x[0]),
        .x2     (coef_x[2]),
        .x4     (coef_x[4]),
        .x6     (coef_x[6]),
        .even_o (even_c)
    );

    idct8_odd_rot u_rot (
        .x1    (coef_x[1]),
        .x3    (coef_x[3]),
        .x5    (coef_x[5]),
        .x7    (coef_x[7]),
        .rot_o (rot_c)
    );

    // Stage enables: a stage advances when it is empty or its successor moves.
    assign s2_en    = !out_valid || out_ready;
    assign s1_en    = !s1_valid || s2_en;
    assign in_ready = s1_en;

    // Stage 1 occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s1_valid <= 1'b0;
        else if (s1_en)
            s1_valid <= in_valid;
    end

    // Stage 1 data: even partials, odd rotation, pixels and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_even  <= '0;
            s1_rot   <= '0;
            s1_pred  <= '0;
            s1_recon <= 1'b0;
        end else if (s1_en && in_valid) begin
            s1_even  <= even_c;
            s1_rot   <= rot_c;
            s1_pred  <= in_pred;
            s1_recon <= in_recon;
        end
    end

    idct8_merge u_merge (
        .even_i (s1_even),
        .rot_i  (s1_rot),
        .y_o    (y_c)
    );

    // Per-lane truncation and reconstruction.
    for (genvar k = 0; k < N_PT; k++) begin : g_lane
        assign res_c[k*COEF_W +: COEF_W] = y_c[k][COEF_W-1:0];

        idct8_recon_lane #(
            .PIX_W    (PIX_W),
            .SCALE_SH (SCALE_SH)
        ) u_lane (
            .y_i     (y_c[k]),
            .pred_i  (s1_pred[k*PIX_W +: PIX_W]),
            .recon_i (s1_recon),
            .pix_o   (pix_c[k*PIX_W +: PIX_W])
        );
    end

    // Output stage occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_valid <= 1'b0;
        else if (s2_en)
            out_valid <= s1_valid;
    end

    // Output stage data, held while the consumer stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_res   <= '0;
            out_pix   <= '0;
            out_recon <= 1'b0;
        end else if (s2_en && s1_valid) begin
            out_res   <= res_c;
            out_pix   <= pix_c;
            out_recon <= s1_recon;
        end
    end

    // R1: the pipeline comes out of reset empty and open.
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

    // R6: a filled first stage reaches the output on the next enabled edge.
    a_r6_one_cycle_hop: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (!out_valid || out_ready)) |=> out_valid);

    // R7: a stalled output does not change.
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_res)
                                       && $stable(out_pix) && $stable(out_recon)));

    // R8: input is refused only when both stages are full and stalled.
    a_r8_refuse_only_full: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (s1_valid && out_valid && !out_ready));

    // R8: an accepted vector occupies stage 1 on the next cycle.
    a_r8_accept_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> s1_valid);

    // R9: an open consumer keeps the input open.
    a_r9_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

    // R10: transform-mode outputs carry no pixels.
    a_r10_pix_zero_transform: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_recon) |-> (out_pix == '0));

endmodule

// File: tb/idct8_recon_bench.sv
// Directed bench for idct8_recon: every scenario is a task. A scoreboard
// records expected results when a vector is accepted and compares them when
// the vector leaves the block. All sampling is done at falling edges.
module idct8_recon_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_coef = '0;
    logic [63:0]  in_pred = '0;
    logic         in_recon = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_res;
    logic [63:0]  out_pix;
    logic         out_recon;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit bp = 1'b0;
    bit done = 1'b0;

    logic [127:0] q_res [1024];
    logic [63:0]  q_pix [1024];
    logic         q_rc  [1024];
    string        q_tag [1024];
    int wr = 0;
    int rd = 0;

    idct8_recon u_idct8_recon (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_coef(in_coef), .in_pred(in_pred), .in_recon(in_recon),
        .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
        .out_pix(out_pix), .out_recon(out_recon)
    );

    always #5 clk = ~clk;

    function automatic longint rq(longint v);
        return (v + 64'sd8192) >>> 14;
    endfunction

    // Reference model built from the requirement equations (R2, R3, R4, R5).
    task automatic ref_model(input logic [127:0] c, input logic [63:0] p,
                             input logic rc, output logic [127:0] res,
                             output logic [63:0] pix);
        longint x[8];
        longint y[8];
        longint p0, p1, p2, p3, a0, a1, a2, a3;
        longint q4, q5, q6, q7, m4, m5, m6, m7, s, t;
        for (int k = 0; k < 8; k++) x[k] = longint'($signed(c[16*k +: 16]));
        p0 = rq((x[0] + x[4]) * 11585);
        p1 = rq((x[0] - x[4]) * 11585);
        p2 = rq(x[2] * 6270 - x[6] * 15137);
        p3 = rq(x[2] * 15137 + x[6] * 6270);
        a0 = p0 + p3; a1 = p1 + p2; a2 = p1 - p2; a3 = p0 - p3;
        q4 = rq(x[1] * 3196 - x[7] * 16069);
        q7 = rq(x[1] * 16069 + x[7] * 3196);
        q5 = rq(x[5] * 13623 - x[3] * 9102);
        q6 = rq(x[5] * 9102 + x[3] * 13623);
        m5 = rq((q7 - q6 - q4 + q5) * 11585);
        m6 = rq((q4 - q5 - q6 + q7) * 11585);
        m4 = q4 + q5; m7 = q6 + q7;
        y[0] = a0 + m7; y[1] = a1 + m6; y[2] = a2 + m5; y[3] = a3 + m4;
        y[4] = a3 - m4; y[5] = a2 - m5; y[6] = a1 - m6; y[7] = a0 - m7;
        for (int k = 0; k < 8; k++) begin
            res[16*k +: 16] = 16'(y[k]);
            s = (y[k] + 16) >>> 5;
            t = longint'(p[8*k +: 8]) + s;
            if (t < 0) t = 0;
            if (t > 255) t = 255;
            pix[8*k +: 8] = rc ? 8'(t) : 8'h00;
        end
    endtask

    task automatic fail(input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
        errors++;
        $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    endtask

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) fail(req, what, act, exp);
    endtask

    // Scoreboard: compare each departing vector against the oldest entry (R3, R4, R8, R10).
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            checks++;
            if (rd == wr) begin
                fail("R8", "output with no accepted vector", 128'(out_res), 128'(0));
            end else begin
                check(q_tag[rd % 1024], "result lanes", out_res, q_res[rd % 1024]);
                check(q_rc[rd % 1024] ? "R4" : "R10", "pixel lanes",
                      128'(out_pix), 128'(q_pix[rd % 1024]));
                check("R10", "mode bit", 128'(out_recon), 128'(q_rc[rd % 1024]));
                rd++;
            end
        end
    end

    // Present one vector until accepted; entered and left just after a rising edge.
    task automatic drive_one(input logic [127:0] c, input logic [63:0] p,
                             input logic rc, input string tag, output int waits);
        logic [127:0] er;
        logic [63:0]  ep;
        in_coef = c; in_pred = p; in_recon = rc; in_valid = 1'b1;
        waits = 0;
        forever begin
            if (bp) out_ready = 1'($urandom_range(0, 1));
            @(negedge clk);
            if (in_ready) begin
                ref_model(c, p, rc, er, ep);
                q_res[wr % 1024] = er; q_pix[wr % 1024] = ep;
                q_rc[wr % 1024] = rc;  q_tag[wr % 1024] = tag;
                wr++;
                @(posedge clk); #1;
                break;
            end
            waits++;
            @(posedge clk); #1;
        end
    endtask

    task automatic drain();
        in_valid = 1'b0; bp = 1'b0; out_ready = 1'b1;
        for (int i = 0; i < 20 && rd != wr; i++) begin
            @(posedge clk); #1;
        end
        check("R8", "vectors left in flight", 128'(wr - rd), 128'(0));
    endtask

    function automatic logic [127:0] splat16(input logic [15:0] v);
        return {8{v}};
    endfunction

    function automatic logic [127:0] rand_coef();
        logic [127:0] c;
        for (int k = 0; k < 8; k++) c[16*k +: 16] = 16'($urandom);
        return c;
    endfunction

    function automatic logic [127:0] extreme_coef();
        logic [127:0] c;
        logic [15:0] pick [4] = '{16'h8000, 16'h7fff, 16'h0000, 16'hffff};
        for (int k = 0; k < 8; k++) c[16*k +: 16] = pick[$urandom_range(0, 3)];
        return c;
    endfunction

    // R1: reset state.
    task automatic t_reset();
        @(negedge clk);
        check("R1", "out_valid during reset", 128'(out_valid), 128'(0));
        check("R1", "in_ready during reset", 128'(in_ready), 128'(1));
        rst_n = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        check("R1", "out_valid after reset", 128'(out_valid), 128'(0));
        check("R1", "out_res after reset", out_res, 128'(0));
        check("R1", "out_pix after reset", 128'(out_pix), 128'(0));
        @(posedge clk); #1;
    endtask

    // R2: hand-worked rounding values, including a DC reconstruct case.
    task automatic t_rounding();
        int w;
        drive_one(128'h1, '0, 1'b0, "R2", w);
        in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R2", "unit DC gives all ones", out_res, splat16(16'h0001));
        @(posedge clk); #1;
        drive_one(128'hffff, '0, 1'b0, "R2", w);
        in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R2", "negative unit DC gives all minus ones", out_res, splat16(16'hffff));
        @(posedge clk); #1;
        drive_one(128'd64, {8{8'd100}}, 1'b1, "R4", w);
        in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R2", "DC 64 gives 45 per lane", out_res, splat16(16'd45));
        check("R4", "DC 64 adds one to pred 100", 128'(out_pix), 128'({8{8'd101}}));
        drain();
    endtask

    // R6: one cycle from acceptance edge to visible output, then empty again.
    task automatic t_latency();
        in_coef = rand_coef(); in_pred = '0; in_recon = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R6", "in_ready before accept", 128'(in_ready), 128'(1));
        begin
            logic [127:0] er; logic [63:0] ep;
            ref_model(in_coef, in_pred, 1'b0, er, ep);
            q_res[wr % 1024] = er; q_pix[wr % 1024] = ep;
            q_rc[wr % 1024] = 1'b0; q_tag[wr % 1024] = "R3"; wr++;
        end
        @(posedge clk); #1; in_valid = 1'b0;
        @(negedge clk);
        check("R6", "out_valid one half-cycle after accept", 128'(out_valid), 128'(0));
        @(negedge clk);
        check("R6", "out_valid one cycle after accept", 128'(out_valid), 128'(1));
        @(negedge clk);
        check("R6", "output empty after departure", 128'(out_valid), 128'(0));
        @(posedge clk); #1;
    endtask

    // R3: random coefficient vectors in transform mode.
    task automatic t_random_transform();
        int w;
        for (int i = 0; i < 120; i++) drive_one(rand_coef(), 64'($urandom), 1'b0, "R3", w);
        drain();
    endtask

    // R3/R4: all-extreme coefficient vectors in both modes.
    task automatic t_extremes();
        int w;
        for (int i = 0; i < 60; i++) drive_one(extreme_coef(), {$urandom, $urandom}, 1'b0, "R3", w);
        for (int i = 0; i < 60; i++) drive_one(extreme_coef(), {$urandom, $urandom}, 1'b1, "R4", w);
        drain();
    endtask

    // R4: random reconstruct vectors with small coefficients and random pixels.
    task automatic t_random_recon();
        int w;
        logic [127:0] c;
        for (int i = 0; i < 120; i++) begin
            for (int k = 0; k < 8; k++) c[16*k +: 16] = 16'($signed(10'($urandom)));
            drive_one(c, {$urandom, $urandom}, 1'b1, "R4", w);
        end
        drain();
    endtask

    // R5: saturation at both ends of the pixel range.
    task automatic t_clamp();
        int w;
        drive_one(128'h7fff, {8{8'd0}}, 1'b1, "R5", w);
        drive_one(128'h8000, {8{8'd255}}, 1'b1, "R5", w);
        in_valid = 1'b0;
        @(negedge clk);
        check("R5", "large positive clamps to 255", 128'(out_pix), 128'({8{8'hff}}));
        @(negedge clk);
        check("R5", "large negative clamps to 0", 128'(out_pix), 128'(0));
        drain();
    endtask

    // R7/R8: fill both stages under a stall, hold, then release.
    task automatic t_stall();
        int w;
        logic [127:0] held;
        logic [127:0] c3;
        out_ready = 1'b0;
        drive_one(rand_coef(), '0, 1'b0, "R8", w);
        drive_one(rand_coef(), {$urandom, $urandom}, 1'b1, "R8", w);
        c3 = rand_coef();
        in_coef = c3;
        @(negedge clk);
        check("R8", "in_ready low with both stages full", 128'(in_ready), 128'(0));
        held = out_res;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7", "out_valid held under stall", 128'(out_valid), 128'(1));
            check("R7", "out_res held under stall", out_res, held);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
        drive_one(c3, '0, 1'b0, "R8", w);
        drain();
    endtask

    // R9: back-to-back acceptance with an open consumer.
    task automatic t_throughput();
        int w;
        int total = 0;
        for (int i = 0; i < 40; i++) begin
            drive_one(rand_coef(), {$urandom, $urandom}, 1'($urandom_range(0, 1)), "R9", w);
            total += w;
        end
        check("R9", "wait cycles at full rate", 128'(total), 128'(0));
        drain();
    endtask

    // R8/R7: random backpressure while mixing both modes.
    task automatic t_backpressure();
        int w;
        bp = 1'b1;
        for (int i = 0; i < 150; i++)
            drive_one(rand_coef(), {$urandom, $urandom}, 1'($urandom_range(0, 1)), "R8", w);
        drain();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog expired: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_rounding();
        t_latency();
        t_random_transform();
        t_extremes();
        t_random_recon();
        t_clamp();
        t_stall();
        t_throughput();
        t_backpressure();
        done = 1'b1;
        finish_run();
    end

endmodule